// File: doc/BRIEF.md
# Processor condition flag register

This block holds the eight status and control bits of a small accumulator CPU. Its layout, from the most significant bit down, is stop-disable, non-maskable mask, half-carry, interrupt mask, negative, zero, overflow and carry. Each cycle the block takes one command from the instruction sequencer. The command is either an arithmetic class, which has the block run its own 8-bit add, subtract, pass-through or decimal-adjust step and update only the flags that class owns, or a register command: a full load, an OR-in of a bit mask, or a clear of a bit mask.

The result of the arithmetic step appears combinationally on `alu_result` in the same cycle, so the datapath can store it at the same edge at which the flags are registered. Three gates use the control bits to qualify a STOP request, the non-maskable request line and a vector of maskable requests before they reach the sequencer and the interrupt logic.

Top module: `status_flags_reg`

## Requirements
- R1: `flags` bits 7..0 are S, X, H, I, N, Z, V, C. A rising clock edge with `rst_n` low sets S, X and I to 1 and leaves H, N, Z, V and C at their previous values.
- R2: Command 8 (load) copies `reg_val` into `flags` at the next edge. The exception is X, which becomes `reg_val[6]` AND the old X, so a load can clear X but never set it again.
- R3: Command 9 ORs `reg_val` into `flags`, except for X, which it leaves unchanged. Command 10 clears every bit that is 1 in `reg_val`, X included.
- R4: Commands 1 (add), 3 (accumulator sum, same arithmetic) and 2 (add plus C) give `alu_result` = a+b(+C) mod 256. At the edge they set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to bit 7 of the result and Z to result==0. S, X and I are unchanged.
- R5: Commands 4 (subtract) and 5 (subtract minus C) give `alu_result` = a-b(-C) mod 256. C is the borrow, V = (a7&~b7&~r7)|(~a7&b7&r7), and N and Z follow the result. H is unchanged.
- R6: Command 6 (pass-through) gives `alu_result` = a. It sets N and Z from a and clears V. H and C are unchanged.
- R7: Command 7 (decimal adjust) adds 0x06 when H=1 or a[3:0]>9. It adds 0x60 when C=1, a[7:4]>9, or a[7:4]==9 with a[3:0]>9. C becomes 1 exactly when 0x60 is added, and N and Z follow the corrected value. H and V are unchanged.
- R8: Command 0 and the unused codes 11..15 leave every flag unchanged and drive `alu_result` to 0.
- R9: `stop_go` = `stop_req` & ~S, `nmi_pass` = `nmi_req` & ~X, and `irq_pass[i]` = `irq_req[i]` & ~I. All three are combinational from the registered flags.
- R10: `alu_result` is valid in the cycle the command is presented. `flags` shows the update after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Command for this cycle |
| opnd_a | input | 8 | First operand (accumulator) |
| opnd_b | input | 8 | Second operand |
| reg_val | input | 8 | Load value or bit mask for commands 8..10 |
| stop_req | input | 1 | STOP request from the sequencer |
| nmi_req | input | 1 | Non-maskable request line |
| irq_req | input | NUM_IRQ | Maskable request lines |
| flags | output | 8 | Registered flag byte |
| alu_result | output | 8 | Combinational arithmetic result |
| stop_go | output | 1 | STOP request allowed |
| nmi_pass | output | 1 | Non-maskable request allowed |
| irq_pass | output | NUM_IRQ | Maskable requests allowed |

## Verification
`alu_result` and the three request gates are combinational, so the bench reads them 1 ns after it drives a command, while the same clock phase is still open. A new flag byte is due one register stage later. The bench drives each command on a falling edge, lets one rising edge pass, and compares `flags` at the following falling edge, when the idle command is already back on the inputs. Every table vector first loads a known flag byte with the load command, so each vector also checks that the flags a class does not own are carried through.

// File: rtl/flagreg_pkg.sv
// flagreg_pkg: command codes, flag bit positions and the per-command update
// mask shared by the flag register and its helpers.
// Assumes an 8-bit flag byte whose bit positions are fixed by the CPU.
package flagreg_pkg;
    localparam int FLAG_W = 8;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    localparam int POS_S = 7;
    localparam int POS_X = 6;
    localparam int POS_H = 5;
    localparam int POS_I = 4;
    localparam int POS_N = 3;
    localparam int POS_Z = 2;
    localparam int POS_V = 1;
    localparam int POS_C = 0;

    typedef enum logic [3:0] {
        OP_IDLE    = 4'd0,
        OP_ADD     = 4'd1,
        OP_ADD_C   = 4'd2,
        OP_ACC_SUM = 4'd3,
        OP_SUB     = 4'd4,
        OP_SUB_C   = 4'd5,
        OP_PASS    = 4'd6,
        OP_DEC_ADJ = 4'd7,
        OP_LOAD    = 4'd8,
        OP_SET_M   = 4'd9,
        OP_CLR_M   = 4'd10
    } op_e;

    // Flags that each arithmetic class is allowed to rewrite.
    function automatic logic [FLAG_W-1:0] upd_mask(op_e op);
        logic [FLAG_W-1:0] m;
        m = '0;
        case (op)
            OP_ADD, OP_ADD_C, OP_ACC_SUM: begin
                m[POS_H] = 1'b1; m[POS_N] = 1'b1; m[POS_Z] = 1'b1;
                m[POS_V] = 1'b1; m[POS_C] = 1'b1;
            end
            OP_SUB, OP_SUB_C: begin
                m[POS_N] = 1'b1; m[POS_Z] = 1'b1;
                m[POS_V] = 1'b1; m[POS_C] = 1'b1;
            end
            OP_PASS: begin
                m[POS_N] = 1'b1; m[POS_Z] = 1'b1; m[POS_V] = 1'b1;
            end
            OP_DEC_ADJ: begin
                m[POS_N] = 1'b1; m[POS_Z] = 1'b1; m[POS_C] = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

    // True for any command that changes nothing.
    function automatic logic is_idle(logic [3:0] code);
        return (code == 4'd0) || (code > 4'd10);
    endfunction
endpackage

// File: rtl/arith_flags.sv
// arith_flags: 8-bit add / subtract / pass-through step and the flag values
// it produces. Purely combinational. Assumes the caller picks which flags
// to keep through the update mask from flagreg_pkg.
module arith_flags
    import flagreg_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              c_in,
    output logic [DATA_W-1:0] result,
    output logic              h_out,
    output logic              n_out,
    output logic              z_out,
    output logic              v_out,
    output logic              c_out
);
    logic [DATA_W:0]  sum_w;
    logic [DATA_W:0]  dif_w;
    logic [NIB_W:0]   low_sum;
    logic             carry_in;
    logic             a_msb, b_msb, r_msb;

    // Carry or borrow input: only the with-carry forms consume C.
    always_comb carry_in = (op == OP_ADD_C || op == OP_SUB_C) ? c_in : 1'b0;

    // Wide sum, wide difference and the low-nibble sum for the half carry.
    always_comb begin
        sum_w   = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, carry_in};
        dif_w   = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, carry_in};
        low_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]}
                + {{NIB_W{1'b0}}, carry_in};
    end

    // Select the result for the class.
    always_comb begin
        case (op)
            OP_ADD, OP_ADD_C, OP_ACC_SUM: result = sum_w[DATA_W-1:0];
            OP_SUB, OP_SUB_C:             result = dif_w[DATA_W-1:0];
            OP_PASS:                      result = a;
            default:                      result = '0;
        endcase
    end

    // Flag values derived from operands and result.
    always_comb begin
        a_msb = a[DATA_W-1];
        b_msb = b[DATA_W-1];
        r_msb = result[DATA_W-1];
        n_out = r_msb;
        z_out = (result == '0);
        h_out = low_sum[NIB_W];
        case (op)
            OP_SUB, OP_SUB_C: begin
                v_out = (a_msb & ~b_msb & ~r_msb) | (~a_msb & b_msb & r_msb);
                c_out = dif_w[DATA_W];
            end
            OP_PASS: begin
                v_out = 1'b0;
                c_out = 1'b0;
            end
            default: begin
                v_out = (a_msb & b_msb & ~r_msb) | (~a_msb & ~b_msb & r_msb);
                c_out = sum_w[DATA_W];
            end
        endcase
    end
endmodule

// File: rtl/decimal_fix.sv
// decimal_fix: corrects a binary sum of two BCD bytes into a valid
// two-digit BCD value from the half-carry and carry flags. Combinational.
// Assumes the input is the accumulator right after a byte addition.
module decimal_fix
    import flagreg_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  logic              h_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] fixed,
    output logic              c_out
);
    localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
    localparam logic [DATA_W-1:0] LOW_CORR  = DATA_W'(8'h06);
    localparam logic [DATA_W-1:0] HIGH_CORR = DATA_W'(8'h60);

    logic [NIB_W-1:0] lo_dig, hi_dig;
    logic             fix_lo, fix_hi;

    // Decide which digit corrections apply.
    always_comb begin
        lo_dig = val[NIB_W-1:0];
        hi_dig = val[DATA_W-1:NIB_W];
        fix_lo = h_in || (lo_dig > DIGIT_MAX);
        fix_hi = c_in || (hi_dig > DIGIT_MAX)
              || ((hi_dig == DIGIT_MAX) && (lo_dig > DIGIT_MAX));
    end

    // Apply the corrections; carry reports the upper one.
    always_comb begin
        fixed = val + (fix_lo ? LOW_CORR : '0) + (fix_hi ? HIGH_CORR : '0);
        c_out = fix_hi;
    end
endmodule

// File: rtl/req_gate.sv
// req_gate: qualifies the STOP request, the non-maskable line and each
// maskable line with the matching control bit. Combinational.
// Assumes a control bit value of 1 means "blocked".
module req_gate #(
    parameter int NUM_IRQ = 4
) (
    input  logic               stop_block,
    input  logic               nmi_block,
    input  logic               irq_block,
    input  logic               stop_req,
    input  logic               nmi_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic               stop_go,
    output logic               nmi_pass,
    output logic [NUM_IRQ-1:0] irq_pass
);
    // Single-line gates.
    always_comb begin
        stop_go  = stop_req & ~stop_block;
        nmi_pass = nmi_req & ~nmi_block;
    end

    // One gate per maskable line.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        always_comb irq_pass[g] = irq_req[g] & ~irq_block;
    end

    // Blocked requests must never pass (R9).
    always_comb begin
        p_stop_blocked_r9: assert (!(stop_block && stop_go));
        p_nmi_blocked_r9:  assert (!(nmi_block && nmi_pass));
        p_irq_blocked_r9:  assert (!(irq_block && (irq_pass != '0)));
    end
endmodule

// File: rtl/status_flags_reg.sv
// status_flags_reg: the CPU's eight-bit flag register. It applies one command
// per cycle (arithmetic class, load, set mask or clear mask) and gates STOP
// and both interrupt classes from the control bits.
// Assumes commands arrive from the sequencer already decoded into op_code.
module status_flags_reg
    import flagreg_pkg::*;
#(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         op_code,
    input  logic [7:0]         opnd_a,
    input  logic [7:0]         opnd_b,
    input  logic [7:0]         reg_val,
    input  logic               stop_req,
    input  logic               nmi_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic [7:0]         flags,
    output logic [7:0]         alu_result,
    output logic               stop_go,
    output logic               nmi_pass,
    output logic [NUM_IRQ-1:0] irq_pass
);
    op_e               op_cur;
    logic [FLAG_W-1:0] flags_q, flags_d, calc_v, mask_v;
    logic [DATA_W-1:0] ar_res, dj_res;
    logic              ar_h, ar_n, ar_z, ar_v, ar_c, dj_c;

    // Decode the raw command.
    always_comb op_cur = op_e'(op_code);

    arith_flags u_arith (
        .op     (op_cur),
        .a      (opnd_a),
        .b      (opnd_b),
        .c_in   (flags_q[POS_C]),
        .result (ar_res),
        .h_out  (ar_h),
        .n_out  (ar_n),
        .z_out  (ar_z),
        .v_out  (ar_v),
        .c_out  (ar_c)
    );

    decimal_fix u_dadj (
        .val   (opnd_a),
        .h_in  (flags_q[POS_H]),
        .c_in  (flags_q[POS_C]),
        .fixed (dj_res),
        .c_out (dj_c)
    );

    // Computed flag candidates and the visible result.
    always_comb begin
        calc_v = flags_q;
        mask_v = upd_mask(op_cur);
        if (op_cur == OP_DEC_ADJ) begin
            alu_result    = dj_res;
            calc_v[POS_N] = dj_res[DATA_W-1];
            calc_v[POS_Z] = (dj_res == '0);
            calc_v[POS_C] = dj_c;
        end else begin
            alu_result    = ar_res;
            calc_v[POS_H] = ar_h;
            calc_v[POS_N] = ar_n;
            calc_v[POS_Z] = ar_z;
            calc_v[POS_V] = ar_v;
            calc_v[POS_C] = ar_c;
        end
    end

    // Next flag byte: register commands first, else masked per-bit merge.
    always_comb begin
        flags_d = flags_q;
        case (op_cur)
            OP_LOAD: begin
                flags_d        = reg_val;
                flags_d[POS_X] = flags_q[POS_X] & reg_val[POS_X];
            end
            OP_SET_M: begin
                flags_d        = flags_q | reg_val;
                flags_d[POS_X] = flags_q[POS_X];
            end
            OP_CLR_M: flags_d = flags_q & ~reg_val;
            default: begin
                for (int i = 0; i < FLAG_W; i++)
                    flags_d[i] = mask_v[i] ? calc_v[i] : flags_q[i];
            end
        endcase
    end

    // Flag storage; reset forces only the three control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q[POS_S] <= 1'b1;
            flags_q[POS_X] <= 1'b1;
            flags_q[POS_I] <= 1'b1;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_comb flags = flags_q;

    req_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .stop_block (flags_q[POS_S]),
        .nmi_block  (flags_q[POS_X]),
        .irq_block  (flags_q[POS_I]),
        .stop_req   (stop_req),
        .nmi_req    (nmi_req),
        .irq_req    (irq_req),
        .stop_go    (stop_go),
        .nmi_pass   (nmi_pass),
        .irq_pass   (irq_pass)
    );

    // First cycle out of reset shows all three control bits set.
    p_reset_masks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags_q[POS_S] && flags_q[POS_X] && flags_q[POS_I]));

    // X only rises through reset.
    p_x_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[POS_X]) |-> $past(!rst_n));

    // Subtract, pass-through and decimal adjust leave H alone.
    p_h_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cur inside {OP_SUB, OP_SUB_C, OP_PASS, OP_DEC_ADJ}) |=> $stable(flags_q[POS_H]));

    // Decimal adjust never clears a set carry.
    p_dadj_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cur == OP_DEC_ADJ && flags_q[POS_C]) |=> flags_q[POS_C]);

    // Idle and unused codes hold every flag.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle(op_code) |=> $stable(flags_q));
endmodule

// File: tb/status_flags_reg_test.sv
`timescale 1ns/100ps
module status_flags_reg_test;
    localparam int NI = 4;
    localparam int NV = 18;
    // {op, a, b, preload, expected result, expected flags}
    localparam logic [43:0] VEC [NV] = '{
        {4'd1, 8'h3A, 8'h48, 8'hD0, 8'h82, 8'hFA},
        {4'd1, 8'hFF, 8'h01, 8'hD0, 8'h00, 8'hF5},
        {4'd2, 8'h10, 8'h20, 8'hD1, 8'h31, 8'hD0},
        {4'd3, 8'h80, 8'h80, 8'hF0, 8'h00, 8'hD7},
        {4'd4, 8'h50, 8'h70, 8'hF0, 8'hE0, 8'hF9},
        {4'd4, 8'h80, 8'h01, 8'hD0, 8'h7F, 8'hD2},
        {4'd5, 8'h05, 8'h04, 8'hD1, 8'h00, 8'hD4},
        {4'd5, 8'h00, 8'h00, 8'hD1, 8'hFF, 8'hD9},
        {4'd6, 8'h00, 8'h55, 8'hD3, 8'h00, 8'hD5},
        {4'd6, 8'h9C, 8'h00, 8'hF6, 8'h9C, 8'hF8},
        {4'd7, 8'h1B, 8'h00, 8'hD0, 8'h21, 8'hD0},
        {4'd7, 8'h9A, 8'h00, 8'hD0, 8'h00, 8'hD5},
        {4'd7, 8'h32, 8'h00, 8'hF0, 8'h38, 8'hF0},
        {4'd7, 8'h12, 8'h00, 8'hD1, 8'h72, 8'hD1},
        {4'd7, 8'hA0, 8'h00, 8'hD2, 8'h00, 8'hD7},
        {4'd0, 8'h12, 8'h34, 8'hDF, 8'h00, 8'hDF},
        {4'd13, 8'h12, 8'h34, 8'hD5, 8'h00, 8'hD5},
        {4'd1, 8'h7F, 8'h01, 8'hD1, 8'h80, 8'hFA}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op_code = 4'd0;
    logic [7:0]    opnd_a = 8'h00, opnd_b = 8'h00, reg_val = 8'h00;
    logic          stop_req = 1'b0, nmi_req = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic [7:0]    flags, alu_result;
    logic          stop_go, nmi_pass;
    logic [NI-1:0] irq_pass;
    int            n_run = 0, n_fail = 0;
    logic [7:0]    res_seen;

    always #2.5 clk = ~clk;

    status_flags_reg #(.NUM_IRQ(NI)) uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .reg_val(reg_val), .stop_req(stop_req),
        .nmi_req(nmi_req), .irq_req(irq_req), .flags(flags),
        .alu_result(alu_result), .stop_go(stop_go), .nmi_pass(nmi_pass),
        .irq_pass(irq_pass)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Present a command for one edge; capture the combinational result.
    task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] v);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; reg_val = v;
        #1 res_seen = alu_result;
        @(negedge clk);
        op_code = 4'd0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd1, 4'd2, 4'd3: return "R4 add";
            4'd4, 4'd5:       return "R5 sub";
            4'd6:             return "R6 pass";
            4'd7:             return "R7 decadj";
            default:          return "R8 idle";
        endcase
    endfunction

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL R10 watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 reset controls", flags & 8'hD0, 8'hD0);

        // Table walk; each vector preloads with X kept at 1.
        for (int k = 0; k < NV; k++) begin
            apply(4'd8, 8'h00, 8'h00, VEC[k][23:16]);
            apply(VEC[k][43:40], VEC[k][39:32], VEC[k][31:24], 8'h00);
            check({tag_of(VEC[k][43:40]), " result R10"}, res_seen, VEC[k][15:8]);
            check({tag_of(VEC[k][43:40]), " flags"}, flags, VEC[k][7:0]);
        end

        // R1: reset keeps the arithmetic flags.
        apply(4'd8, 8'h00, 8'h00, 8'h2F);
        check("R2 load", flags, 8'h2F);
        pulse_reset();
        check("R1 reset retains", flags, 8'hFF);

        // R2: X cannot be set again by a load.
        apply(4'd8, 8'h00, 8'h00, 8'h00);
        check("R2 load zero", flags, 8'h00);
        apply(4'd8, 8'h00, 8'h00, 8'hFF);
        check("R2 X stays clear", flags, 8'hBF);

        // R3: set and clear masks.
        apply(4'd8, 8'h00, 8'h00, 8'h00);
        apply(4'd9, 8'h00, 8'h00, 8'h41);
        check("R3 set no X", flags, 8'h01);
        apply(4'd9, 8'h00, 8'h00, 8'hA4);
        check("R3 set", flags, 8'hA5);
        apply(4'd10, 8'h00, 8'h00, 8'h21);
        check("R3 clear", flags, 8'h84);
        pulse_reset();
        check("R1 reset partial", flags, 8'hD4);
        apply(4'd10, 8'h00, 8'h00, 8'h40);
        check("R3 clear X", flags, 8'h94);

        // R9: request gates.
        pulse_reset();
        @(negedge clk);
        stop_req = 1'b1; nmi_req = 1'b1; irq_req = '1;
        #1 check("R9 all blocked", {5'b0, stop_go, nmi_pass, |irq_pass}, 8'h00);
        apply(4'd10, 8'h00, 8'h00, 8'hD0);
        #1 check("R9 all pass", {stop_go, nmi_pass, 2'b0, irq_pass}, {2'b11, 2'b00, {NI{1'b1}}});
        apply(4'd9, 8'h00, 8'h00, 8'h10);
        #1 check("R9 irq masked", {stop_go, nmi_pass, 2'b0, irq_pass}, 8'hC0);
        apply(4'd9, 8'h00, 8'h00, 8'h80);
        #1 check("R9 stop masked", {stop_go, nmi_pass, 6'b0}, 8'h40);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule